// File: doc/BRIEF.md
# Normalising Barrel Shifter

This block is a 16-bit shifter controlled by a 4-bit opcode. It shifts a data word by 0 to 15 places. The shift can be logical (zero fill), arithmetic right (sign fill) or a rotate. The shift amount comes from one of four places:

- the shift-amount port;
- amount register A;
- amount register B;
- a leading-sign counter.

The leading-sign counter drives the normalise opcodes. These shift out the redundant sign bits of the word and report how many places were removed.

The opcode, the shift-amount port and the data word are captured together on a rising clock edge. The result and the port drive signals are valid for the whole cycle that follows that edge. The amount registers are written at the end of that cycle, so the next instruction sees the new value.

The bidirectional shift-amount port is modelled as three parts:

- a separate input bus;
- a separate output bus;
- an output enable.

A strap input holds the port in input-only mode. A synchronous clear zeroes both amount registers.

Top module: `shf_normaliser`

## Requirements
- R1: Opcode 0 shifts right and opcode 1 shifts left by the captured port value. Vacated bits are filled with zeros.
- R2: Opcode 2 rotates right and opcode 3 rotates left by the captured port value. Bits that leave one end re-enter at the other end.
- R3: Opcode 10 shifts right by the captured port value and fills vacated bits with copies of the original bit 15.
- R4: Opcodes 4 (right), 5 (left) and 11 (arithmetic right) take their amount from register A. Opcodes 6, 7 and 12 do the same with register B. The port value is ignored for all six.
- R5: Opcodes 8 and 9 pass the data through unshifted. At the end of the cycle they write the captured port value into register A or register B. The instruction that follows uses the new value.
- R6: Opcodes 13 to 15 normalise. The word is shifted left with zero fill until bit 15 differs from bit 14, by at most 15 places. A word of all zeros or all ones gives a count of 15.
- R7: During opcodes 13 to 15, with the strap low, `sv_oe` is 1 and `sv_out` carries the normalise count.
- R8: Opcode 14 writes the normalise count into register A at the end of the cycle. Opcode 15 writes it into register B.
- R9: For opcodes 0 to 12, `sv_oe` is 0 and `sv_out` is 0. The port value is an operand only for opcodes 0 to 3 and 8 to 10.
- R10: With `sv_in_only` high, `sv_oe` and `sv_out` stay 0 for every opcode. Normalise still shifts the word and still writes its count into the register.
- R11: The opcode, port value and data are captured on a rising edge. The outputs reflect them from that edge until the next one.
- R12: `clr` high at a rising edge zeroes both amount registers at that edge. It overrides a register write that would otherwise happen at the same edge.
- R13: After reset, both amount registers are zero, `data_out` is 0 and `sv_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of both amount registers |
| sv_in_only | input | 1 | Strap: when high, the port never drives |
| op_in | input | 4 | Opcode, captured at the rising edge |
| sv_in | input | 4 | Shift-amount port, input side |
| data_in | input | 16 | Word to shift, captured at the rising edge |
| data_out | output | 16 | Shifted word for the current instruction |
| sv_out | output | 4 | Shift-amount port, output side (normalise count) |
| sv_oe | output | 1 | Output enable of the shift-amount port |

## Verification
The bench targets the following corner cases:

- **Normalise extremes** (all zeros, all ones, a lone low bit, an already-normal word). A wrong sign-run counter gives counts that are off by one here, or wraps to 0 at the limit.
- **Register timing.** A write is followed at once by a shift that uses the register. Separately, a clear arrives on the same edge as a pending write. A design that writes a cycle late, or lets the write beat the clear, shows a wrong shift amount.
- **Shift boundaries** (amounts of 0 and 15, rotates of sign-heavy words, arithmetic shifts of negative words). These expose a swapped fill or a left/right reversal.
- **Strap.** With the strap high the port must stay quiet while a normalise still stores its count.

// File: rtl/shf_pkg.sv
package shf_pkg;

  localparam int SHF_DATA_W = 16;
  localparam int SHF_OP_W   = 4;

  typedef enum logic [SHF_OP_W-1:0] {
    OP_LSR_V  = 4'h0,
    OP_LSL_V  = 4'h1,
    OP_ROR_V  = 4'h2,
    OP_ROL_V  = 4'h3,
    OP_LSR_A  = 4'h4,
    OP_LSL_A  = 4'h5,
    OP_LSR_B  = 4'h6,
    OP_LSL_B  = 4'h7,
    OP_SET_A  = 4'h8,
    OP_SET_B  = 4'h9,
    OP_ASR_V  = 4'hA,
    OP_ASR_A  = 4'hB,
    OP_ASR_B  = 4'hC,
    OP_NORM   = 4'hD,
    OP_NORM_A = 4'hE,
    OP_NORM_B = 4'hF
  } shf_op_e;

  function automatic logic op_is_norm(shf_op_e op);
    return (op == OP_NORM) || (op == OP_NORM_A) || (op == OP_NORM_B);
  endfunction

endpackage

// File: rtl/shf_sign_count.sv
// Counts the bits below the MSB that repeat the sign before the first change.
module shf_sign_count #(
  parameter int W  = shf_pkg::SHF_DATA_W,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  output logic [AW-1:0] cnt
);

  function automatic logic [AW-1:0] sign_run(logic [W-1:0] v);
    logic [AW-1:0] c;
    logic          stop;
    c    = '0;
    stop = 1'b0;
    for (int i = W - 2; i >= 0; i--) begin
      if (!stop && (v[i] == v[W-1])) c = c + 1'b1;
      else stop = 1'b1;
    end
    return c;
  endfunction

  assign cnt = sign_run(din);

endmodule

// File: rtl/shf_rshift_net.sv
// Logarithmic right shifter; one stage per amount bit, rotate or fill per stage.
module shf_rshift_net #(
  parameter int W  = shf_pkg::SHF_DATA_W,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  input  logic          rot,
  input  logic          fill,
  output logic [W-1:0]  dout
);

  logic [AW:0][W-1:0] st;
  assign st[0] = din;

  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int D = 1 << k;
    logic [W-1:0] moved;
    assign moved    = rot ? {st[k][D-1:0], st[k][W-1:D]}
                          : {{D{fill}}, st[k][W-1:D]};
    assign st[k+1]  = amt[k] ? moved : st[k];
  end

  assign dout = st[AW];

endmodule

// File: rtl/shf_ctrl.sv
// Opcode decode, amount registers, amount source select and port drive.
module shf_ctrl
  import shf_pkg::*;
#(
  parameter int AW = $clog2(SHF_DATA_W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          sv_in_only,
  input  shf_op_e       op_q,
  input  logic [AW-1:0] sv_q,
  input  logic [AW-1:0] norm_cnt,
  output logic [AW-1:0] amt,
  output logic          dir_left,
  output logic          rot,
  output logic          arith,
  output logic [AW-1:0] sv_out,
  output logic          sv_oe
);

  logic [AW-1:0] amt_a, amt_b;
  logic          ld_a, ld_b;
  logic [AW-1:0] ld_a_val, ld_b_val;
  logic          port_drive;

  always_comb begin
    amt      = '0;
    dir_left = 1'b0;
    rot      = 1'b0;
    arith    = 1'b0;
    case (op_q)
      OP_LSR_V:  amt = sv_q;
      OP_LSL_V:  begin amt = sv_q;  dir_left = 1'b1; end
      OP_ROR_V:  begin amt = sv_q;  rot = 1'b1; end
      OP_ROL_V:  begin amt = sv_q;  rot = 1'b1; dir_left = 1'b1; end
      OP_LSR_A:  amt = amt_a;
      OP_LSL_A:  begin amt = amt_a; dir_left = 1'b1; end
      OP_LSR_B:  amt = amt_b;
      OP_LSL_B:  begin amt = amt_b; dir_left = 1'b1; end
      OP_SET_A,
      OP_SET_B:  amt = '0;
      OP_ASR_V:  begin amt = sv_q;  arith = 1'b1; end
      OP_ASR_A:  begin amt = amt_a; arith = 1'b1; end
      OP_ASR_B:  begin amt = amt_b; arith = 1'b1; end
      default:   begin amt = norm_cnt; dir_left = 1'b1; end
    endcase
  end

  assign ld_a     = (op_q == OP_SET_A) || (op_q == OP_NORM_A);
  assign ld_b     = (op_q == OP_SET_B) || (op_q == OP_NORM_B);
  assign ld_a_val = (op_q == OP_SET_A) ? sv_q : norm_cnt;
  assign ld_b_val = (op_q == OP_SET_B) ? sv_q : norm_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      amt_a <= '0;
      amt_b <= '0;
    end else if (clr) begin
      amt_a <= '0;
      amt_b <= '0;
    end else begin
      if (ld_a) amt_a <= ld_a_val;
      if (ld_b) amt_b <= ld_b_val;
    end
  end

  assign port_drive = op_is_norm(op_q);
  assign sv_oe      = port_drive && !sv_in_only;
  assign sv_out     = sv_oe ? norm_cnt : '0;

  // R5: a port-value write lands at the end of the instruction's cycle
  a_r5_set_a: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_q == OP_SET_A && !clr) |-> amt_a == $past(sv_q));
  a_r5_set_b: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_q == OP_SET_B && !clr) |-> amt_b == $past(sv_q));
  // R8: normalise count is stored by the loading normalise opcodes
  a_r8_norm_a: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_q == OP_NORM_A && !clr) |-> amt_a == $past(norm_cnt));
  // R12: clear wins over any write at the same edge
  a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> (amt_a == '0) && (amt_b == '0));
  // R4: shifts that read a register leave both registers untouched
  a_r4_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ld_a && !ld_b) |=> $stable(amt_a) && $stable(amt_b));

endmodule

// File: rtl/shf_normaliser.sv
module shf_normaliser
  import shf_pkg::*;
#(
  parameter int W  = SHF_DATA_W,
  parameter int AW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          sv_in_only,
  input  logic [3:0]    op_in,
  input  logic [AW-1:0] sv_in,
  input  logic [W-1:0]  data_in,
  output logic [W-1:0]  data_out,
  output logic [AW-1:0] sv_out,
  output logic          sv_oe
);

  shf_op_e       op_q;
  logic [AW-1:0] sv_q;
  logic [W-1:0]  data_q;

  logic [AW-1:0] norm_cnt;
  logic [AW-1:0] amt;
  logic          dir_left, rot, arith, fill;
  logic [W-1:0]  net_in, net_out;

  function automatic logic [W-1:0] bit_rev(logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_LSR_V;
      sv_q   <= '0;
      data_q <= '0;
    end else begin
      op_q   <= shf_op_e'(op_in);
      sv_q   <= sv_in;
      data_q <= data_in;
    end
  end

  shf_sign_count #(.W(W), .AW(AW)) u_count (
    .din (data_q),
    .cnt (norm_cnt)
  );

  shf_ctrl #(.AW(AW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .sv_in_only (sv_in_only),
    .op_q       (op_q),
    .sv_q       (sv_q),
    .norm_cnt   (norm_cnt),
    .amt        (amt),
    .dir_left   (dir_left),
    .rot        (rot),
    .arith      (arith),
    .sv_out     (sv_out),
    .sv_oe      (sv_oe)
  );

  assign fill   = arith & data_q[W-1];
  assign net_in = dir_left ? bit_rev(data_q) : data_q;

  shf_rshift_net #(.W(W), .AW(AW)) u_net (
    .din  (net_in),
    .amt  (amt),
    .rot  (rot),
    .fill (fill),
    .dout (net_out)
  );

  assign data_out = dir_left ? bit_rev(net_out) : net_out;

  // R6: a normalised word has differing top bits unless the limit was hit
  a_r6_norm_differs: assert property (@(posedge clk) disable iff (!rst_n)
    (op_is_norm(op_q) && norm_cnt != AW'(W-1)) |-> data_out[W-1] != data_out[W-2]);
  // R2: a rotate keeps every bit
  a_r2_rot_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_ROR_V || op_q == OP_ROL_V) |-> $countones(data_out) == $countones(data_q));
  // R3: arithmetic right shift keeps the sign
  a_r3_sign_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_ASR_V || op_q == OP_ASR_A || op_q == OP_ASR_B) |-> data_out[W-1] == data_q[W-1]);
  // R10: strap silences the port
  a_r10_strap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    sv_in_only |-> !sv_oe);
  // R5: register write opcodes pass data unshifted
  a_r5_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_SET_A || op_q == OP_SET_B) |-> data_out == data_q);
  // R9: the port drives only for normalise opcodes
  a_r9_oe_norm_only: assert property (@(posedge clk) disable iff (!rst_n)
    sv_oe |-> op_is_norm(op_q));

endmodule

// File: tb/shf_normaliser_test.sv
`timescale 1ns/1ps
module shf_normaliser_test;

  localparam int W  = 16;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr = 1'b0;
  logic          sv_in_only = 1'b0;
  logic [3:0]    op_in = '0;
  logic [AW-1:0] sv_in = '0;
  logic [W-1:0]  data_in = '0;
  logic [W-1:0]  data_out;
  logic [AW-1:0] sv_out;
  logic          sv_oe;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  shf_normaliser uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .sv_in_only(sv_in_only),
    .op_in(op_in), .sv_in(sv_in), .data_in(data_in),
    .data_out(data_out), .sv_out(sv_out), .sv_oe(sv_oe)
  );

  // bench model of the amount registers
  logic [3:0] m_a = '0, m_b = '0;
  logic       pend_a = 0, pend_b = 0;
  logic [3:0] pend_a_v = '0, pend_b_v = '0;

  logic [15:0] q_out[$];
  logic        q_oe[$];
  logic [3:0]  q_sv[$];
  string       q_tag[$];
  string       q_ptag[$];

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_count(logic [15:0] d, output logic [15:0] res);
    logic [15:0] v = d;
    int c = 0;
    while (c < 15 && v[15] == v[14]) begin
      v = v << 1;
      c++;
    end
    res = v;
    return 4'(c);
  endfunction

  function automatic logic [15:0] ref_out(logic [3:0] op, logic [3:0] sv, logic [15:0] d,
                                          logic [3:0] ra, logic [3:0] rb);
    logic [31:0] dd = {d, d};
    logic [15:0] nres;
    logic [3:0]  c;
    c = ref_count(d, nres);
    case (op)
      4'h0: return d >> sv;
      4'h1: return d << sv;
      4'h2: return 16'(dd >> sv);
      4'h3: return 16'((dd << sv) >> 16);
      4'h4: return d >> ra;
      4'h5: return d << ra;
      4'h6: return d >> rb;
      4'h7: return d << rb;
      4'h8, 4'h9: return d;
      4'hA: return 16'($signed(d) >>> sv);
      4'hB: return 16'($signed(d) >>> ra);
      4'hC: return 16'($signed(d) >>> rb);
      default: return nres;
    endcase
  endfunction

  function automatic string tag_of(logic [3:0] op);
    case (op)
      4'h0, 4'h1: return "R1";
      4'h2, 4'h3: return "R2";
      4'hA: return "R3";
      4'h4, 4'h5, 4'h6, 4'h7, 4'hB, 4'hC: return "R4";
      4'h8, 4'h9: return "R5";
      4'hE, 4'hF: return "R8";
      default: return "R6";
    endcase
  endfunction

  task automatic step(logic [3:0] op, logic [3:0] sv, logic [15:0] d,
                      logic c_clr, logic strap, string tag);
    logic [15:0] nres;
    logic [3:0]  cnt;
    logic        norm;
    string       ptag;
    @(negedge clk);
    op_in = op; sv_in = sv; data_in = d; clr = c_clr; sv_in_only = strap;
    // edge that latches this item applies the previous item's write, or clear
    if (c_clr) begin
      m_a = '0; m_b = '0;
    end else begin
      if (pend_a) m_a = pend_a_v;
      if (pend_b) m_b = pend_b_v;
    end
    cnt  = ref_count(d, nres);
    norm = (op >= 4'hD);
    q_out.push_back(ref_out(op, sv, d, m_a, m_b));
    q_oe.push_back(norm && !strap);
    q_sv.push_back((norm && !strap) ? cnt : 4'h0);
    q_tag.push_back(tag);
    ptag = strap ? "R10" : (norm ? "R7" : "R9");
    q_ptag.push_back(ptag);
    pend_a = (op == 4'h8) || (op == 4'hE);
    pend_b = (op == 4'h9) || (op == 4'hF);
    pend_a_v = (op == 4'h8) ? sv : cnt;
    pend_b_v = (op == 4'h9) ? sv : cnt;
  endtask

  // monitor: results appear after the edge that latched the item
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_out.size() > 0) begin
        automatic logic [15:0] eo = q_out.pop_front();
        automatic logic        ee = q_oe.pop_front();
        automatic logic [3:0]  es = q_sv.pop_front();
        automatic string       t  = q_tag.pop_front();
        automatic string       pt = q_ptag.pop_front();
        check(t, "data_out", 32'(data_out), 32'(eo));
        check(pt, "sv_oe", 32'(sv_oe), 32'(ee));
        check(pt, "sv_out", 32'(sv_out), 32'(es));
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R13", "reset data_out", 32'(data_out), 32'h0);
    check("R13", "reset sv_oe", 32'(sv_oe), 32'h0);
    check("R13", "reset sv_out", 32'(sv_out), 32'h0);
    // registers zero after reset: register shifts leave data unchanged
    step(4'h4, 4'h7, 16'h8000, 0, 0, "R13");
    step(4'h7, 4'h7, 16'h0001, 0, 0, "R13");
    // R1 logical shifts by the port value
    step(4'h0, 4'h4, 16'h8421, 0, 0, "R1");
    step(4'h1, 4'h3, 16'h8421, 0, 0, "R1");
    step(4'h0, 4'h0, 16'hBEEF, 0, 0, "R1");
    step(4'h1, 4'hF, 16'hFFFF, 0, 0, "R1");
    step(4'h0, 4'hF, 16'h8000, 0, 0, "R1");
    // R2 rotates
    step(4'h2, 4'h4, 16'h1234, 0, 0, "R2");
    step(4'h3, 4'hC, 16'h1234, 0, 0, "R2");
    step(4'h2, 4'hF, 16'h8001, 0, 0, "R2");
    step(4'h3, 4'h0, 16'hC3A5, 0, 0, "R2");
    // R3 arithmetic right
    step(4'hA, 4'h5, 16'h8F00, 0, 0, "R3");
    step(4'hA, 4'h3, 16'h7F00, 0, 0, "R3");
    step(4'hA, 4'hF, 16'hFFFE, 0, 0, "R3");
    // R5 write then immediate use; R4 ignores the port value
    step(4'h8, 4'h6, 16'hABCD, 0, 0, "R5");
    step(4'h4, 4'h9, 16'hF0F0, 0, 0, "R4");
    step(4'h9, 4'h3, 16'h1357, 0, 0, "R5");
    step(4'h6, 4'hA, 16'hF0F0, 0, 0, "R4");
    step(4'h7, 4'h1, 16'h00FF, 0, 0, "R4");
    step(4'h5, 4'h2, 16'h00FF, 0, 0, "R4");
    step(4'hB, 4'h0, 16'h9000, 0, 0, "R4");
    step(4'hC, 4'h0, 16'h9000, 0, 0, "R4");
    // R6 normalise extremes
    step(4'hD, 4'h0, 16'h0001, 0, 0, "R6");
    step(4'hD, 4'h0, 16'h0000, 0, 0, "R6");
    step(4'hD, 4'h0, 16'hFFFF, 0, 0, "R6");
    step(4'hD, 4'h0, 16'hC000, 0, 0, "R6");
    step(4'hD, 4'h0, 16'h4000, 0, 0, "R6");
    step(4'hD, 4'h0, 16'h0300, 0, 0, "R6");
    // R8 stored counts used by the next instruction
    step(4'hE, 4'h0, 16'h0020, 0, 0, "R8");
    step(4'h5, 4'h0, 16'h0001, 0, 0, "R8");
    step(4'hF, 4'h0, 16'hFFF0, 0, 0, "R8");
    step(4'h7, 4'h0, 16'h0001, 0, 0, "R8");
    // R10 strap: port quiet, count still stored
    step(4'hE, 4'h0, 16'h0004, 0, 1, "R10");
    step(4'h5, 4'h0, 16'h0003, 0, 1, "R10");
    step(4'hD, 4'h0, 16'h0000, 0, 1, "R10");
    // R12 clear beats a pending write
    step(4'h8, 4'h7, 16'h1111, 0, 0, "R12");
    step(4'h4, 4'h0, 16'h8000, 1, 0, "R12");
    step(4'h9, 4'h5, 16'h2222, 0, 0, "R12");
    step(4'h6, 4'h0, 16'h8000, 0, 0, "R12");
    step(4'h6, 4'h0, 16'h8000, 1, 0, "R12");
    // R11 a new word and opcode every cycle
    for (int i = 0; i < 8; i++)
      step(4'(i % 4), 4'(i + 1), 16'(16'h1 << i) ^ 16'hA5A5, 0, 0, "R11");
    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      automatic logic [3:0]  op = 4'($urandom_range(0, 15));
      automatic logic [15:0] d  = 16'($urandom);
      automatic int          k  = $urandom_range(0, 3);
      if (k == 0) d = 16'h0;
      if (k == 1) d = 16'(d >>> $urandom_range(0, 15));
      step(op, 4'($urandom), d, ($urandom_range(0, 19) == 0),
           ($urandom_range(0, 7) == 0), tag_of(op));
    end
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule